// File: doc/BRIEF.md
# Match-Based Watchdog With Escalation

This block is a watchdog timer built around a free-running up-counter. The counter advances on a one-cycle tick-enable pulse that comes from a slow low-power time base, so everything runs in one clock domain. On each tick the counter is compared with a programmable match value. A programmable number of the counter's upper bits can be left out of that compare. This shortens the compare space to 2^(16 - N) ticks, so it wraps that often.

While the system is active, match events escalate. The first two matches move an escalation stage forward and raise an interrupt status bit. The third match raises a reset request. While the low-power mode input is high, the very first match raises the reset request directly. Software keeps the watchdog quiet by servicing it before the third match, which returns the stage to zero. The reset request is sticky until the system reset arrives.

A small write port controls the block. A two-step key sequence opens a write lock. While the lock is closed, writes to the match, compare-width, enable, service and counter-reset controls are dropped. The current count, the stage, the enable, the lock and the interrupt signals are visible on output ports.

Top module: `mwdt_top`

## Requirements
- R1: After reset the count is 0, the block is disabled and locked, the stage is 0, reset_req_o, irq_status_o and irq_o are 0, the match value and the ignore count are 0, and the interrupt is unmasked.
- R2: A write to address 0 (key) of 16'hC0DE arms the unlock. The next key write of 16'hFACE, while armed, opens the lock. Any other key write, including 16'hFACE when not armed, closes the lock. The armed state is set only by a write of 16'hC0DE.
- R3: While locked, writes to the match register (address 2), the ignore register (address 3) and the enable, service and counter-reset bits of the control register (address 1) have no effect.
- R4: While enabled, the count increases by 1 (wrapping at 16 bits) on the clock edge of each tick pulse. While disabled it holds.
- R5: The ignore register takes wr_data[3:0]; a value above 12 is stored as 12. With N ignored bits, a match occurs on a tick while enabled when the low 16-N bits of the count equal those of the match value.
- R6: With low-power mode low, the first and second matches move the stage from 0 to 1 and then to 2. The third match, seen with stage 2, sets reset_req_o. With match M and ignore count N, starting from count 0, the reset request follows the tick at count M + 2*2^(16-N).
- R7: A match with lp_mode_i high sets reset_req_o on that match, whatever the stage.
- R8: Once set, reset_req_o stays high until rst_n is asserted. Service does not clear it.
- R9: Control bit 2 (service), while unlocked, sets the stage to 0 on the next edge and overrides a match on the same edge.
- R10: Control bit 1 (disable) is accepted even while locked. It clears the enable, sets the stage to 0 and leaves the block unlocked. When set with bit 0 (enable), it wins. Bit 0 alone, while unlocked, enables.
- R11: Control bit 3 (counter reset), while unlocked, is registered first. The count still reads its old value one cycle after the write and reads 0 one cycle later. The clear overrides a tick on that edge.
- R12: Each non-final active match sets irq_status_o. A write to address 4 with bit 0 set clears the status, and a set on the same edge wins. Bit 1 of that write sets the mask. irq_o = irq_status_o and not mask. Address 4 is not lock-guarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_i | input | 1 | One-cycle tick enable from the slow time base |
| lp_mode_i | input | 1 | High while the system is in the low-power mode |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address (0 key, 1 control, 2 match, 3 ignore, 4 interrupt) |
| wr_data_i | input | 16 | Register write data |
| count_o | output | 16 | Current counter value |
| stage_o | output | 2 | Escalation stage |
| enabled_o | output | 1 | Watchdog enabled |
| locked_o | output | 1 | Write lock closed |
| irq_status_o | output | 1 | Interrupt status |
| irq_o | output | 1 | Interrupt status not masked |
| reset_req_o | output | 1 | Sticky reset request |

## Verification
Every output comes from a register, so each write or tick shows its effect one clock edge later. The counter reset is the exception: its effect shows two edges later, because the command is registered first. The bench drives inputs on the falling edge and compares all outputs 1 ns after the next rising edge against a bench model stepped on that same edge. The directed checks for the counter-reset delay, the third-match timing and the single match in low-power mode sample at exactly the edge computed from the tick count.

// File: rtl/mwdt_pkg.sv
package mwdt_pkg;
  localparam int AD_W = 3;

  localparam logic [AD_W-1:0] ADR_KEY   = 3'd0;
  localparam logic [AD_W-1:0] ADR_CTRL  = 3'd1;
  localparam logic [AD_W-1:0] ADR_MATCH = 3'd2;
  localparam logic [AD_W-1:0] ADR_IGN   = 3'd3;
  localparam logic [AD_W-1:0] ADR_IRQ   = 3'd4;

  localparam logic [15:0] KEY_ARM  = 16'hC0DE;
  localparam logic [15:0] KEY_OPEN = 16'hFACE;

  localparam int CB_EN   = 0;
  localparam int CB_DIS  = 1;
  localparam int CB_SVC  = 2;
  localparam int CB_CRST = 3;

  localparam int IB_CLR  = 0;
  localparam int IB_MASK = 1;
endpackage

// File: rtl/mwdt_regs.sv
module mwdt_regs
  import mwdt_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int MAX_IGN = 12,
  localparam int IGN_W  = $clog2(MAX_IGN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AD_W-1:0]  wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic             locked,
  output logic             enabled,
  output logic [CNT_W-1:0] match_val,
  output logic [IGN_W-1:0] ign_bits,
  output logic             svc_p,
  output logic             dis_p,
  output logic             crst_p,
  output logic             irq_clr_p,
  output logic             irq_mask
);

  logic             lock_q, lock_d;
  logic             arm_q, arm_d;
  logic             en_q, en_d;
  logic [CNT_W-1:0] match_q, match_d;
  logic [IGN_W-1:0] ign_q, ign_d;
  logic             mask_q, mask_d;

  logic key_w, ctl_w, match_w, ign_w, irq_w, ena_p;
  logic [IGN_W-1:0] ign_in;

  assign key_w   = wr_en && (wr_addr == ADR_KEY);
  assign ctl_w   = wr_en && (wr_addr == ADR_CTRL);
  assign match_w = wr_en && (wr_addr == ADR_MATCH) && !lock_q;
  assign ign_w   = wr_en && (wr_addr == ADR_IGN) && !lock_q;
  assign irq_w   = wr_en && (wr_addr == ADR_IRQ);

  assign dis_p     = ctl_w && wr_data[CB_DIS];
  assign ena_p     = ctl_w && wr_data[CB_EN] && !lock_q;
  assign svc_p     = ctl_w && wr_data[CB_SVC] && !lock_q;
  assign crst_p    = ctl_w && wr_data[CB_CRST] && !lock_q;
  assign irq_clr_p = irq_w && wr_data[IB_CLR];

  assign ign_in = wr_data[IGN_W-1:0];

  always_comb begin
    lock_d  = lock_q;
    arm_d   = arm_q;
    en_d    = en_q;
    match_d = match_q;
    ign_d   = ign_q;
    mask_d  = mask_q;
    if (key_w) begin
      lock_d = !(arm_q && (wr_data == CNT_W'(KEY_OPEN)));
      arm_d  = (wr_data == CNT_W'(KEY_ARM));
    end
    if (dis_p) begin
      en_d   = 1'b0;
      lock_d = 1'b0;
    end else if (ena_p) begin
      en_d = 1'b1;
    end
    if (match_w) match_d = wr_data;
    if (ign_w)   ign_d = (ign_in > IGN_W'(MAX_IGN)) ? IGN_W'(MAX_IGN) : ign_in;
    if (irq_w)   mask_d = wr_data[IB_MASK];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q  <= 1'b1;
      arm_q   <= 1'b0;
      en_q    <= 1'b0;
      match_q <= '0;
      ign_q   <= '0;
      mask_q  <= 1'b0;
    end else begin
      lock_q  <= lock_d;
      arm_q   <= arm_d;
      en_q    <= en_d;
      match_q <= match_d;
      ign_q   <= ign_d;
      mask_q  <= mask_d;
    end
  end

  assign locked    = lock_q;
  assign enabled   = en_q;
  assign match_val = match_q;
  assign ign_bits  = ign_q;
  assign irq_mask  = mask_q;

  AST_LOCK_KEEPS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && wr_en && wr_addr == ADR_MATCH) |=> $stable(match_q)); // R3
  AST_LOCK_KEEPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && ctl_w && !wr_data[CB_DIS] && !en_q) |=> !en_q); // R3
  AST_IGN_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    ign_w |=> (ign_q <= IGN_W'(MAX_IGN))); // R5
  AST_DIS_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    dis_p |=> (!lock_q && !en_q)); // R10
  AST_BAD_KEY_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (key_w && !arm_q) |=> lock_q); // R2

endmodule

// File: rtl/mwdt_counter.sv
module mwdt_counter #(
  parameter int CNT_W   = 16,
  parameter int MAX_IGN = 12,
  localparam int IGN_W  = $clog2(MAX_IGN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             enabled,
  input  logic             crst_p,
  input  logic [CNT_W-1:0] match_val,
  input  logic [IGN_W-1:0] ign_bits,
  output logic [CNT_W-1:0] count,
  output logic             hit
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             clrp_q;
  logic [CNT_W-1:0] cmp_mask;
  logic             adv;

  for (genvar b = 0; b < CNT_W; b++) begin : g_mask
    assign cmp_mask[b] = ((32'(ign_bits) + b) < CNT_W);
  end

  assign adv = enabled && tick;
  assign hit = adv && (((cnt_q ^ match_val) & cmp_mask) == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (clrp_q)   cnt_d = '0;
    else if (adv) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      clrp_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      clrp_q <= crst_p;
    end
  end

  assign count = cnt_q;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clrp_q) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R4
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clrp_q) |=> $stable(cnt_q)); // R4
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    crst_p |=> ##1 (cnt_q == '0)); // R11

endmodule

// File: rtl/mwdt_escalate.sv
module mwdt_escalate #(
  parameter int ACT_MATCHES = 3,
  localparam int ST_W = $clog2(ACT_MATCHES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hit,
  input  logic            lp_mode,
  input  logic            clr_stage,
  input  logic            irq_clr,
  output logic [ST_W-1:0] stage,
  output logic            reset_req,
  output logic            irq_status
);

  localparam logic [ST_W-1:0] LAST = ST_W'(ACT_MATCHES - 1);

  logic [ST_W-1:0] stage_q, stage_d;
  logic            rreq_q, rreq_d;
  logic            irqs_q, irqs_d;
  logic            irq_set;

  always_comb begin
    stage_d = stage_q;
    rreq_d  = rreq_q;
    irq_set = 1'b0;
    if (clr_stage) begin
      stage_d = '0;
    end else if (hit) begin
      if (lp_mode || stage_q == LAST) begin
        rreq_d = 1'b1;
      end else begin
        stage_d = stage_q + ST_W'(1);
        irq_set = 1'b1;
      end
    end
    irqs_d = irqs_q;
    if (irq_set)      irqs_d = 1'b1;
    else if (irq_clr) irqs_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      rreq_q  <= 1'b0;
      irqs_q  <= 1'b0;
    end else begin
      stage_q <= stage_d;
      rreq_q  <= rreq_d;
      irqs_q  <= irqs_d;
    end
  end

  assign stage      = stage_q;
  assign reset_req  = rreq_q;
  assign irq_status = irqs_q;

  AST_RREQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rreq_q |=> rreq_q); // R8
  AST_LP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && lp_mode && !clr_stage) |=> rreq_q); // R7
  AST_FINAL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && stage_q == LAST && !clr_stage) |=> rreq_q); // R6
  AST_SVC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stage |=> (stage_q == '0)); // R9
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |=> irqs_q); // R12

endmodule

// File: rtl/mwdt_top.sv
module mwdt_top
  import mwdt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int MAX_IGN     = 12,
  parameter int ACT_MATCHES = 3,
  localparam int IGN_W      = $clog2(MAX_IGN + 1),
  localparam int ST_W       = $clog2(ACT_MATCHES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             lp_mode_i,
  input  logic             wr_en_i,
  input  logic [AD_W-1:0]  wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] count_o,
  output logic [ST_W-1:0]  stage_o,
  output logic             enabled_o,
  output logic             locked_o,
  output logic             irq_status_o,
  output logic             irq_o,
  output logic             reset_req_o
);

  logic [1:0] rsync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  logic             en_w, svc_w, dis_w, crst_w, iclr_w, mask_w, hit_w, irqs_w;
  logic [CNT_W-1:0] match_w;
  logic [IGN_W-1:0] ign_w;

  mwdt_regs #(.CNT_W(CNT_W), .MAX_IGN(MAX_IGN)) u_regs (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .wr_en     (wr_en_i),
    .wr_addr   (wr_addr_i),
    .wr_data   (wr_data_i),
    .locked    (locked_o),
    .enabled   (en_w),
    .match_val (match_w),
    .ign_bits  (ign_w),
    .svc_p     (svc_w),
    .dis_p     (dis_w),
    .crst_p    (crst_w),
    .irq_clr_p (iclr_w),
    .irq_mask  (mask_w)
  );

  mwdt_counter #(.CNT_W(CNT_W), .MAX_IGN(MAX_IGN)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .tick      (tick_i),
    .enabled   (en_w),
    .crst_p    (crst_w),
    .match_val (match_w),
    .ign_bits  (ign_w),
    .count     (count_o),
    .hit       (hit_w)
  );

  mwdt_escalate #(.ACT_MATCHES(ACT_MATCHES)) u_esc (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .hit        (hit_w),
    .lp_mode    (lp_mode_i),
    .clr_stage  (svc_w || dis_w),
    .irq_clr    (iclr_w),
    .stage      (stage_o),
    .reset_req  (reset_req_o),
    .irq_status (irqs_w)
  );

  assign enabled_o    = en_w;
  assign irq_status_o = irqs_w;
  assign irq_o        = irqs_w && !mask_w;

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_s_n)
    mask_w |-> !irq_o); // R12

endmodule

// File: tb/sim_mwdt_top.sv
`timescale 1ns/1ps
module sim_mwdt_top;
  import mwdt_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick, lp, we;
  logic [2:0]  addr;
  logic [15:0] data;
  logic [15:0] count_o;
  logic [1:0]  stage_o;
  logic        enabled_o, locked_o, irq_status_o, irq_o, reset_req_o;

  int vectors = 0;
  int fails = 0;
  logic lp_cur = 1'b0;

  always #2 clk = ~clk;

  mwdt_top u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .lp_mode_i(lp),
    .wr_en_i(we), .wr_addr_i(addr), .wr_data_i(data),
    .count_o(count_o), .stage_o(stage_o), .enabled_o(enabled_o),
    .locked_o(locked_o), .irq_status_o(irq_status_o), .irq_o(irq_o),
    .reset_req_o(reset_req_o)
  );

  // bench model state
  logic        m_lock, m_arm, m_en, m_clrp, m_rst, m_irqs, m_mask;
  logic [15:0] m_match, m_cnt;
  logic [3:0]  m_ign;
  logic [1:0]  m_stage;

  task automatic model_reset();
    m_lock = 1; m_arm = 0; m_en = 0; m_clrp = 0; m_rst = 0; m_irqs = 0;
    m_mask = 0; m_match = 0; m_cnt = 0; m_ign = 0; m_stage = 0;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_step(input logic t, input logic l, input logic w,
                            input logic [2:0] a, input logic [15:0] d);
    logic unl, key_w, ctl_w, dis, ena, svc, crst, mw, iw, qw, hit, iset;
    logic [15:0] cm;
    unl   = !m_lock;
    key_w = w && a == ADR_KEY;
    ctl_w = w && a == ADR_CTRL;
    dis   = ctl_w && d[1];
    ena   = ctl_w && d[0] && unl;
    svc   = ctl_w && d[2] && unl;
    crst  = ctl_w && d[3] && unl;
    mw    = w && a == ADR_MATCH && unl;
    iw    = w && a == ADR_IGN && unl;
    qw    = w && a == ADR_IRQ;
    cm    = 16'hFFFF >> m_ign;
    hit   = m_en && t && (((m_cnt ^ m_match) & cm) == 16'h0);
    iset  = 0;
    if (svc || dis) m_stage = 0;
    else if (hit) begin
      if (l || m_stage == 2) m_rst = 1;
      else begin m_stage = m_stage + 2'd1; iset = 1; end
    end
    if (iset) m_irqs = 1;
    else if (qw && d[0]) m_irqs = 0;
    if (m_clrp) m_cnt = 0;
    else if (m_en && t) m_cnt = m_cnt + 16'd1;
    m_clrp = crst;
    if (key_w) begin
      m_lock = !(m_arm && d == KEY_OPEN);
      m_arm  = (d == KEY_ARM);
    end
    if (dis) begin m_en = 0; m_lock = 0; end
    else if (ena) m_en = 1;
    if (mw) m_match = d;
    if (iw) m_ign = (d[3:0] > 4'd12) ? 4'd12 : d[3:0];
    if (qw) m_mask = d[1];
  endtask

  task automatic compare_all();
    chk("R4", "count", int'(count_o), int'(m_cnt));
    chk("R6", "stage", int'(stage_o), int'(m_stage));
    chk("R8", "reset_req", int'(reset_req_o), int'(m_rst));
    chk("R12", "irq_status", int'(irq_status_o), int'(m_irqs));
    chk("R12", "irq", int'(irq_o), int'(m_irqs && !m_mask));
    chk("R10", "enabled", int'(enabled_o), int'(m_en));
    chk("R2", "locked", int'(locked_o), int'(m_lock));
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic drive(input logic t, input logic w, input logic [2:0] a, input logic [15:0] d);
    tick = t; lp = lp_cur; we = w; addr = a; data = d;
    @(posedge clk);
    model_step(t, lp_cur, w, a, d);
    #1;
    compare_all();
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    drive(1'b0, 1'b1, a, d);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) drive(1'b1, 1'b0, 3'd0, 16'h0);
  endtask

  task automatic unlock();
    wr(ADR_KEY, KEY_ARM);
    wr(ADR_KEY, KEY_OPEN);
  endtask

  task automatic sys_reset();
    tick = 0; we = 0; addr = 0; data = 0; lp = 0; lp_cur = 0;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) drive(1'b0, 1'b0, 3'd0, 16'h0);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; tick = 0; lp = 0; we = 0; addr = 0; data = 0;
    model_reset();
    @(negedge clk);
    sys_reset();

    // R1 reset state
    chk("R1", "count", int'(count_o), 0);
    chk("R1", "locked", int'(locked_o), 1);
    chk("R1", "enabled", int'(enabled_o), 0);
    chk("R1", "reset_req", int'(reset_req_o), 0);
    chk("R1", "irq", int'(irq_o), 0);

    // R3 / R2 lock behaviour
    wr(ADR_CTRL, 16'h0001);
    chk("R3", "enabled after locked enable", int'(enabled_o), 0);
    wr(ADR_KEY, KEY_OPEN);
    chk("R2", "locked after open key alone", int'(locked_o), 1);
    unlock();
    chk("R2", "locked after key pair", int'(locked_o), 0);

    // R5, R6, R12: ignore 15 clamps to 12, match 5 -> matches at 5, 21, 37
    wr(ADR_IGN, 16'h000F);
    wr(ADR_MATCH, 16'h0005);
    wr(ADR_CTRL, 16'h0001);
    ticks(6);
    chk("R6", "stage after first match", int'(stage_o), 1);
    chk("R12", "irq after first match", int'(irq_o), 1);
    wr(ADR_IRQ, 16'h0002);
    chk("R12", "irq when masked", int'(irq_o), 0);
    chk("R12", "status when masked", int'(irq_status_o), 1);
    wr(ADR_IRQ, 16'h0003);
    chk("R12", "status after clear", int'(irq_status_o), 0);
    wr(ADR_IRQ, 16'h0000);
    ticks(31);
    chk("R5", "reset_req before third match", int'(reset_req_o), 0);
    chk("R6", "stage before third match", int'(stage_o), 2);
    ticks(1);
    chk("R6", "reset_req after third match", int'(reset_req_o), 1);
    wr(ADR_CTRL, 16'h0004);
    chk("R8", "reset_req after service", int'(reset_req_o), 1);
    chk("R9", "stage after service", int'(stage_o), 0);
    sys_reset();

    // R7 low-power: match 3, first match resets
    unlock();
    wr(ADR_IGN, 16'd12);
    wr(ADR_MATCH, 16'd3);
    wr(ADR_CTRL, 16'h0001);
    lp_cur = 1'b1;
    ticks(3);
    chk("R7", "reset_req before match", int'(reset_req_o), 0);
    ticks(1);
    chk("R7", "reset_req on first match", int'(reset_req_o), 1);
    sys_reset();

    // R9 service, R11 counter reset, R3 locked, R10 disable, R4 hold
    unlock();
    wr(ADR_IGN, 16'd12);
    wr(ADR_MATCH, 16'd2);
    wr(ADR_CTRL, 16'h0001);
    ticks(3);
    chk("R9", "stage before service", int'(stage_o), 1);
    wr(ADR_CTRL, 16'h0004);
    chk("R9", "stage after service", int'(stage_o), 0);
    wr(ADR_CTRL, 16'h0008);
    chk("R11", "count one cycle after reset cmd", int'(count_o), 3);
    drive(1'b0, 1'b0, 3'd0, 16'h0);
    chk("R11", "count two cycles after reset cmd", int'(count_o), 0);
    ticks(2);
    wr(ADR_KEY, 16'h0000);
    chk("R2", "locked after relock", int'(locked_o), 1);
    wr(ADR_CTRL, 16'h0008);
    drive(1'b0, 1'b0, 3'd0, 16'h0);
    chk("R3", "count after locked reset cmd", int'(count_o), 2);
    wr(ADR_CTRL, 16'h0003);
    chk("R10", "enabled after locked disable", int'(enabled_o), 0);
    chk("R10", "locked after disable", int'(locked_o), 0);
    ticks(4);
    chk("R4", "count while disabled", int'(count_o), 2);

    // random phase
    sys_reset();
    for (int i = 0; i < 4000; i++) begin
      logic t, w;
      logic [2:0] a;
      logic [15:0] d;
      int r;
      t = ($urandom % 100) < 60;
      w = ($urandom % 100) < 20;
      lp_cur = ($urandom % 100) < 8;
      a = 3'($urandom % 5);
      r = $urandom % 100;
      if (a == ADR_KEY) d = (r < 40) ? KEY_ARM : (r < 80) ? KEY_OPEN : 16'($urandom);
      else if (a == ADR_CTRL) d = (r < 50) ? 16'h0001 : 16'($urandom % 16);
      else if (a == ADR_IGN) d = 16'(8 + ($urandom % 8));
      else d = 16'($urandom);
      drive(t, w, a, d);
      if (m_rst && (($urandom % 8) == 0)) sys_reset();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule